// File: doc/BRIEF.md
# UART Status Flags and Interrupt Request Unit

This block keeps the eight event flags of an asynchronous serial port in one read-only status byte. The transmit and receive shifters drive it with one-cycle event strobes. A small CPU register bus reads the flags and clears them. Each flag is set by hardware. It is cleared only by a two-step software sequence: first a read of the status register, then an access to the data register. A data write ends the sequence for the transmit flags. A data read ends it for the receive flags.

The flags are gated with their enable inputs and combined into one registered, level-sensitive interrupt request. The same request can wake the core while it is in wait mode. It never wakes the core from halt. The block also tells the transmit shifter when it may take a new byte.

Top module: `uart_sts_irq`

## Requirements
- R1: After reset the status byte is 0xC0 (TDRE and TC set, every other flag clear), and the interrupt request and wake outputs are low.
- R2: Status bit positions are 7 TDRE, 6 TC, 5 RDRF, 4 IDLE, 3 overrun, 2 noise, 1 framing, 0 parity. A strobe on tx_load_i, rx_load_i, idle_i, overrun_i, noise_i, frame_err_i or parity_err_i sets its bit, which is visible on status_o from the next clock edge.
- R3: A tx_done_i strobe sets TC only when tx_kind_i is 0 (data frame). Kind 1 (preamble) and kind 2 (break) leave TC unchanged.
- R4: TDRE and TC clear when a status read (address 0) is followed by a data write (address 1). A data read does not clear them.
- R5: RDRF and bits 4 to 0 clear when a status read is followed by a data read (address 1). A data write does not clear them.
- R6: A status read arms the clear sequence. Any later read or write to an address other than the status register disarms it, including the data access that completes the sequence. A data access made while the sequence is not armed clears nothing.
- R7: When a set strobe and a clearing data access fall in the same cycle, the flag ends up set.
- R8: irq_o rises one cycle after a flag is set while its enable is high. The flag/enable pairs are TDRE with tie_i, TC with tcie_i, RDRF with rie_i, IDLE with ilie_i, and parity with pie_i. irq_o stays high as long as an enabled flag stays set, and falls one cycle after the last enabled flag clears.
- R9: wake_o is high only when irq_o is high, wait_mode_i is high and halt_mode_i is low.
- R10: tx_ready_o is high exactly when TDRE is clear. The shifter may assert tx_load_i only while tx_ready_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Register select: 0 status, 1 data, other values are other registers |
| reg_rd_i | input | 1 | Bus read strobe |
| reg_wr_i | input | 1 | Bus write strobe |
| tx_load_i | input | 1 | Transmit byte moved into the shift register |
| tx_done_i | input | 1 | Transmit frame finished |
| tx_kind_i | input | 2 | Kind of the finished frame: 0 data, 1 preamble, 2 break |
| rx_load_i | input | 1 | Received byte moved into the data register |
| idle_i | input | 1 | Idle line detected |
| overrun_i | input | 1 | Receive overrun |
| noise_i | input | 1 | Noise detected |
| frame_err_i | input | 1 | Framing error |
| parity_err_i | input | 1 | Parity error |
| tie_i | input | 1 | TDRE interrupt enable |
| tcie_i | input | 1 | TC interrupt enable |
| rie_i | input | 1 | RDRF interrupt enable |
| ilie_i | input | 1 | Idle interrupt enable |
| pie_i | input | 1 | Parity interrupt enable |
| wait_mode_i | input | 1 | Core is in wait mode |
| halt_mode_i | input | 1 | Core is in halt mode |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Registered interrupt request |
| wake_o | output | 1 | Wake request out of wait mode |
| tx_ready_o | output | 1 | The shifter may load a new byte |

## Verification
The assertions assume that the bus never reads and writes in the same cycle. They also assume that the transmit shifter asserts tx_load_i only while TDRE is clear, as R10 requires. The random stimulus keeps to both rules: it draws at most one bus strobe per cycle, and it gates each tx_load_i draw with the bench's own expected TDRE value. The directed steps follow the same rules.

// File: rtl/uart_sts_pkg.sv
package uart_sts_pkg;
  localparam int unsigned FLAG_N = 8;
  localparam int unsigned B_TDRE = 7;
  localparam int unsigned B_TC   = 6;
  localparam int unsigned B_RDRF = 5;
  localparam int unsigned B_IDLE = 4;
  localparam int unsigned B_OVR  = 3;
  localparam int unsigned B_NF   = 2;
  localparam int unsigned B_FE   = 1;
  localparam int unsigned B_PE   = 0;

  localparam logic [FLAG_N-1:0] RESET_FLAGS = 8'hC0;
  localparam logic [FLAG_N-1:0] TX_GROUP    = 8'hC0;
  localparam logic [FLAG_N-1:0] RX_GROUP    = 8'h3F;

  typedef enum logic [1:0] {
    FRM_DATA     = 2'd0,
    FRM_PREAMBLE = 2'd1,
    FRM_BREAK    = 2'd2
  } frame_kind_e;
endpackage

// File: rtl/sts_access_arm.sv
module sts_access_arm #(
  parameter int unsigned ADDR_W = 2,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = '0,
  parameter logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic              clr_tx_o,
  output logic              clr_rx_o
);
  logic armed_q;
  logic st_rd, data_sel;

  assign st_rd    = rd_i && (addr_i == STATUS_ADDR);
  assign data_sel = (addr_i == DATA_ADDR);

  // status read arms; any other access disarms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            armed_q <= 1'b0;
    else if (st_rd)         armed_q <= 1'b1;
    else if (rd_i || wr_i)  armed_q <= 1'b0;
  end

  assign clr_tx_o = armed_q && wr_i && data_sel;
  assign clr_rx_o = armed_q && rd_i && data_sel;

  p_single_access_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && wr_i));
  p_arm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_rd |=> armed_q);
  p_disarm_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && (addr_i != STATUS_ADDR)) |=> !armed_q);
  p_clr_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_tx_o && clr_rx_o));
endmodule

// File: rtl/sts_flag_bank.sv
module sts_flag_bank #(
  parameter int unsigned N = 8,
  parameter logic [N-1:0] RESET_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= RESET_VAL[i];
      else if (set_i[i]) bit_q <= 1'b1;  // set beats clear
      else if (clr_i[i]) bit_q <= 1'b0;
    end
    assign flags_o[i] = bit_q;

    p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flags_o[i]);
    p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !flags_o[i]);
    p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[i] && !clr_i[i]) |=> $stable(flags_o[i]));
  end
endmodule

// File: rtl/sts_irq_gen.sv
module sts_irq_gen #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  input  logic         wait_i,
  input  logic         halt_i,
  output logic         irq_o,
  output logic         wake_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flags_i & en_i);
  end

  assign irq_o  = irq_q;
  assign wake_o = irq_q && wait_i && !halt_i;

  p_irq_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flags_i & en_i)) |=> irq_o);
  p_irq_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(flags_i & en_i)) |=> !irq_o);
  p_halt_no_wake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> !wake_o);
endmodule

// File: rtl/uart_sts_irq.sv
module uart_sts_irq
  import uart_sts_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = '0,
  parameter logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic              tx_load_i,
  input  logic              tx_done_i,
  input  logic [1:0]        tx_kind_i,
  input  logic              rx_load_i,
  input  logic              idle_i,
  input  logic              overrun_i,
  input  logic              noise_i,
  input  logic              frame_err_i,
  input  logic              parity_err_i,
  input  logic              tie_i,
  input  logic              tcie_i,
  input  logic              rie_i,
  input  logic              ilie_i,
  input  logic              pie_i,
  input  logic              wait_mode_i,
  input  logic              halt_mode_i,
  output logic [7:0]        status_o,
  output logic              irq_o,
  output logic              wake_o,
  output logic              tx_ready_o
);
  logic              clr_tx, clr_rx;
  logic [FLAG_N-1:0] set_vec, clr_vec, en_vec, flags;
  logic              tc_evt;

  sts_access_arm #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_arm (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .rd_i(reg_rd_i), .wr_i(reg_wr_i),
    .clr_tx_o(clr_tx), .clr_rx_o(clr_rx)
  );

  // preamble and break completions do not count
  assign tc_evt = tx_done_i && (frame_kind_e'(tx_kind_i) == FRM_DATA);

  always_comb begin
    set_vec         = '0;
    set_vec[B_TDRE] = tx_load_i;
    set_vec[B_TC]   = tc_evt;
    set_vec[B_RDRF] = rx_load_i;
    set_vec[B_IDLE] = idle_i;
    set_vec[B_OVR]  = overrun_i;
    set_vec[B_NF]   = noise_i;
    set_vec[B_FE]   = frame_err_i;
    set_vec[B_PE]   = parity_err_i;
    en_vec          = '0;
    en_vec[B_TDRE]  = tie_i;
    en_vec[B_TC]    = tcie_i;
    en_vec[B_RDRF]  = rie_i;
    en_vec[B_IDLE]  = ilie_i;
    en_vec[B_PE]    = pie_i;
  end

  assign clr_vec = ({FLAG_N{clr_tx}} & TX_GROUP) | ({FLAG_N{clr_rx}} & RX_GROUP);

  sts_flag_bank #(.N(FLAG_N), .RESET_VAL(RESET_FLAGS)) u_flags (
    .clk_i, .rst_ni, .set_i(set_vec), .clr_i(clr_vec), .flags_o(flags)
  );

  sts_irq_gen #(.N(FLAG_N)) u_irq (
    .clk_i, .rst_ni, .flags_i(flags), .en_i(en_vec),
    .wait_i(wait_mode_i), .halt_i(halt_mode_i),
    .irq_o, .wake_o
  );

  assign status_o   = flags;
  assign tx_ready_o = !flags[B_TDRE];

  p_tc_kind_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && tx_kind_i != 2'd0 && !status_o[B_TC]) |=> !status_o[B_TC]);
  p_tx_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_i |-> tx_ready_o);
  p_tx_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && status_o[B_TDRE]) |=> status_o[B_TDRE]);
endmodule

// File: tb/sim_uart_sts_irq.sv
module sim_uart_sts_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic rd = 0, wr = 0, tx_load = 0, tx_done = 0, rx_load = 0;
  logic [1:0] kind = '0;
  logic idle = 0, ovr = 0, nf = 0, fe = 0, pe = 0;
  logic tie = 0, tcie = 0, rie = 0, ilie = 0, pie = 0, wt = 0, hl = 0;
  logic [7:0] status;
  logic irq, wake, ready;

  int total = 0, bad = 0;
  logic [7:0] m_flags = 8'hC0;
  logic m_armed = 0, m_irq = 0;

  always #10 clk = ~clk;

  uart_sts_irq u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr),
    .tx_load_i(tx_load), .tx_done_i(tx_done), .tx_kind_i(kind), .rx_load_i(rx_load),
    .idle_i(idle), .overrun_i(ovr), .noise_i(nf), .frame_err_i(fe), .parity_err_i(pe),
    .tie_i(tie), .tcie_i(tcie), .rie_i(rie), .ilie_i(ilie), .pie_i(pie),
    .wait_mode_i(wt), .halt_mode_i(hl),
    .status_o(status), .irq_o(irq), .wake_o(wake), .tx_ready_o(ready)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] next_flags(logic [7:0] f, logic armed);
    logic [7:0] s, c;
    s = {tx_load, tx_done && kind == 2'd0, rx_load, idle, ovr, nf, fe, pe};
    c = {{2{armed && wr && addr == 2'd1}}, {6{armed && rd && addr == 2'd1}}};
    return s | (f & ~c);
  endfunction

  function automatic logic irq_of(logic [7:0] f);
    return |(f & {tie, tcie, rie, ilie, 3'b000, pie});
  endfunction

  task automatic quiet();
    rd = 0; wr = 0; tx_load = 0; tx_done = 0; rx_load = 0;
    idle = 0; ovr = 0; nf = 0; fe = 0; pe = 0; kind = '0;
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic cyc(string tag);
    @(posedge clk);
    m_irq   = irq_of(m_flags);
    m_flags = next_flags(m_flags, m_armed);
    if (rd && addr == 2'd0) m_armed = 1;
    else if (rd || wr)      m_armed = 0;
    @(negedge clk);
    chk({tag, " status"}, status, m_flags);
    chk("R8 irq", {7'd0, irq}, {7'd0, m_irq});
    chk("R9 wake", {7'd0, wake}, {7'd0, m_irq && wt && !hl});
    chk("R10 ready", {7'd0, ready}, {7'd0, !m_flags[7]});
    quiet();
  endtask

  task automatic bus(logic r, logic w, logic [1:0] a, string tag);
    rd = r; wr = w; addr = a;
    cyc(tag);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 8'hC0);
    chk("R1 reset irq", {6'd0, irq, wake}, 8'h00);
    chk("R10 reset ready", {7'd0, ready}, 8'h00);
    rst_n = 1;
    cyc("R1");

    // R4: status read then data write clears TDRE and TC
    bus(1, 0, 2'd1, "R4");               // data read, not armed
    chk("R4 data read keeps tx", status, 8'hC0);
    bus(1, 0, 2'd0, "R4");
    bus(1, 0, 2'd1, "R4");               // armed data read: rx group only
    chk("R4 read no tx clear", status, 8'hC0);
    bus(1, 0, 2'd0, "R4");
    bus(0, 1, 2'd1, "R4");
    chk("R4 cleared", status, 8'h00);
    chk("R10 ready after clear", {7'd0, ready}, 8'h01);

    // R3: only data frames set TC
    tx_done = 1; kind = 2'd1; cyc("R3");
    tx_done = 1; kind = 2'd2; cyc("R3");
    chk("R3 preamble/break", status, 8'h00);
    tx_done = 1; kind = 2'd0; cyc("R3");
    chk("R3 data frame", status, 8'h40);

    // R2: receive-side strobes
    rx_load = 1; cyc("R2");
    chk("R2 rdrf bit5", status, 8'h60);
    idle = 1; ovr = 1; nf = 1; fe = 1; pe = 1; cyc("R2");
    chk("R2 all rx bits", status, 8'h7F);

    // R5/R6
    bus(1, 0, 2'd0, "R5");
    bus(0, 1, 2'd1, "R5");
    chk("R5 write keeps rx", status, 8'h3F);
    bus(1, 0, 2'd1, "R6");
    chk("R6 unarmed read", status, 8'h3F);
    bus(1, 0, 2'd0, "R6");
    bus(1, 0, 2'd2, "R6");
    bus(1, 0, 2'd1, "R6");
    chk("R6 disarmed by other reg", status, 8'h3F);
    bus(1, 0, 2'd0, "R5");
    bus(1, 0, 2'd1, "R5");
    chk("R5 rx cleared", status, 8'h00);

    // R7: set wins over clear
    bus(1, 0, 2'd0, "R7");
    rx_load = 1; rd = 1; addr = 2'd1; cyc("R7");
    chk("R7 set wins", status, 8'h20);

    // R8/R9
    rie = 1; cyc("R8");
    chk("R8 irq up", {7'd0, irq}, 8'h01);
    wt = 1; cyc("R9");
    chk("R9 wake in wait", {7'd0, wake}, 8'h01);
    hl = 1; cyc("R9");
    chk("R9 no wake in halt", {7'd0, wake}, 8'h00);
    hl = 0;
    bus(1, 0, 2'd0, "R8");
    bus(1, 0, 2'd1, "R8");
    chk("R8 irq lags clear", {7'd0, irq}, 8'h01);
    cyc("R8");
    chk("R8 irq down", {7'd0, irq}, 8'h00);

    // R10
    tx_load = 1; cyc("R10");
    chk("R10 busy after load", {7'd0, ready}, 8'h00);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = $urandom_range(0, 5);
      addr = 2'($urandom_range(0, 3));
      if (op == 0 || op == 1) rd = 1;
      else if (op == 2) wr = 1;
      tx_load = !m_flags[7] && ($urandom_range(0, 3) == 0);
      tx_done = ($urandom_range(0, 5) == 0);
      kind    = 2'($urandom_range(0, 2));
      rx_load = ($urandom_range(0, 7) == 0);
      idle = ($urandom_range(0, 15) == 0);
      ovr  = ($urandom_range(0, 15) == 0);
      nf   = ($urandom_range(0, 15) == 0);
      fe   = ($urandom_range(0, 15) == 0);
      pe   = ($urandom_range(0, 15) == 0);
      if (n % 50 == 0) begin
        {tie, tcie, rie, ilie, pie} = 5'($urandom);
        wt = 1'($urandom); hl = 1'($urandom);
      end
      cyc("R2 R6 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule